// File: doc/BRIEF.md
# Protected-Configuration Watchdog Timer

This block is a watchdog timer for a small microcontroller. It counts ticks from a slow oscillator, supplied as a one-cycle enable pulse on the system clock. When the count reaches the programmed period, it either requests an interrupt or requests a system reset. A single 8-bit control/status register holds the configuration. Software writes it through a plain write strobe and reads it back on a parallel output. Writes have no handshake and no back-pressure: a write is taken on every clock edge where the write strobe is high.

Changes that could weaken protection need a timed unlock. A first write opens a short change window. During that window the enable bit can be cleared and the prescaler can be changed. The timeout action depends on the enable bits, giving three modes: interrupt only, interrupt first and reset on the next timeout, or reset only. Acknowledging the interrupt clears the interrupt-enable bit, so in the combined mode the next timeout resets the system. After a watchdog-caused reset, the block restarts at its shortest period with the reset flag set. While that flag is set, the enable bit cannot be cleared.

Top module: `wdt_timer`

## Requirements
- R1: The timeout period is 2^(BASE_LOG2 + ps) oscillator ticks, where ps is the 4-bit prescaler field. BASE_LOG2 defaults to 11, giving 2048 ticks at ps = 0. The counter only advances on clock edges where `osc_tick` is high, and the timeout action registers on the edge of the last tick.
- R2: While the window is closed, a write with both the change bit (bit 2) and the enable bit (bit 0) set opens the window. That write sets only the change bit. The change bit clears itself on the fourth clock edge after the opening write.
- R3: A write made while the window is closed can set the enable bit but never clear it. It writes the interrupt-enable bit (bit 1) directly and leaves the prescaler unchanged. It clears the reset flag (bit 3) if that bit of the write data is 0.
- R4: A write made while the window is open updates the enable bit, the interrupt-enable bit, the prescaler (bits 7:4) and the reset flag (cleared by writing 0). It also closes the window. If the reset flag was set before the write, the enable bit stays 1.
- R5: A timeout with interrupt-enable clear and enable set raises `sys_rst_req` for exactly one cycle.
- R6: A timeout with interrupt-enable set raises `irq`. `irq` stays high until `irq_ack`, and counting restarts for a new full period.
- R7: `irq_ack` clears `irq` and the interrupt-enable bit. With enable set, the next timeout then resets the system.
- R8: In the cycle `sys_rst_req` is high, the register reads enable = 1, reset flag = 1, ps = 0, and interrupt-enable and change bits = 0.
- R9: `restart` sets the count back to zero whenever enable or interrupt-enable is set.
- R10: Any change of the active state (enable OR interrupt-enable) or of the prescaler restarts the count. With both enable bits clear, no timeout ever occurs.
- R11: After power-on reset, the register reads 0 and both `irq` and `sys_rst_req` are low.
- R12: `reg_rdata` always shows the register as {ps[3:0], reset flag, change bit, interrupt-enable, enable}, from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register contents |
| osc_tick | input | 1 | Slow oscillator tick enable |
| restart | input | 1 | Watchdog restart strobe |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request, held until acknowledged |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The in-RTL assertions check these properties on every cycle:
- the count stays below the current period and sits at zero while the watchdog is inactive;
- the reset flag implies the enable bit, and enable cannot drop while the window is closed;
- the reset request lasts one cycle and coincides with the post-reset defaults;
- the interrupt holds until acknowledged.

Only the bench scenarios can show the following:
- the exact period lengths for several prescaler values;
- the four-edge window length;
- the interrupt-then-reset sequence after an acknowledge;
- that regular restarts prevent any reset.

A cycle-accurate reference model, fed with random writes, ticks, restarts and acknowledges, covers how these interact.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PS_W   = 4;
  localparam int B_EN   = 0;
  localparam int B_IE   = 1;
  localparam int B_CE   = 2;
  localparam int B_RF   = 3;
  localparam int B_PS   = 4;
  typedef logic [PS_W-1:0] ps_t;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 11
) (
  input  logic clk,
  input  logic por_n,
  input  logic active,
  input  ps_t  ps,
  input  logic tick,
  input  logic clr,
  output logic expire
);
  localparam int CW = BASE_LOG2 + (1 << PS_W) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    lim    = {{(CW-1){1'b0}}, 1'b1} << (BASE_LOG2 + 32'(ps));
    expire = active && tick && (cnt == lim - 1'b1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                cnt <= '0;
    else if (clr || !active)   cnt <= '0;
    else if (tick)             cnt <= cnt + 1'b1;
  end

  // R1: count never reaches the period limit
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!por_n)
    cnt < lim);
  // R10: an inactive watchdog holds its count at zero
  a_r10_stopped: assert property (@(posedge clk) disable iff (!por_n)
    !active |=> cnt == '0);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CE_HOLD = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  input  logic       irq_ack,
  input  logic       expire,
  output logic       en,
  output logic       ie,
  output logic       ce,
  output logic       rf,
  output ps_t        ps,
  output logic       irq,
  output logic       sys_rst_req,
  output logic       cfg_chg
);
  localparam int CEW = (CE_HOLD > 2) ? $clog2(CE_HOLD) : 1;

  logic [CEW-1:0] cec, n_cec;
  logic n_en, n_ie, n_ce, n_rf, n_irq, fire;
  ps_t  n_ps;

  always_comb begin
    n_en  = en;  n_ie = ie;  n_ce = ce;  n_rf = rf;
    n_ps  = ps;  n_cec = cec;
    fire  = expire && !ie && en;
    if (fire) begin
      n_en = 1'b1; n_ie = 1'b0; n_ce = 1'b0; n_rf = 1'b1;
      n_ps = '0;   n_cec = '0;
    end else begin
      if (reg_we) begin
        if (ce) begin
          n_en = reg_wdata[B_EN] | rf;
          n_ie = reg_wdata[B_IE];
          n_ps = reg_wdata[B_PS +: PS_W];
          n_rf = rf & reg_wdata[B_RF];
          n_ce = 1'b0;
        end else if (reg_wdata[B_CE] && reg_wdata[B_EN]) begin
          n_ce  = 1'b1;
          n_cec = CEW'(CE_HOLD - 1);
        end else begin
          n_en = en | reg_wdata[B_EN];
          n_ie = reg_wdata[B_IE];
          n_rf = rf & reg_wdata[B_RF];
        end
      end else if (ce) begin
        if (cec == '0) n_ce  = 1'b0;
        else           n_cec = cec - 1'b1;
      end
      if (irq_ack) n_ie = 1'b0;
    end
    n_irq   = (expire && ie) ? 1'b1 : (irq_ack ? 1'b0 : irq);
    cfg_chg = ((n_en | n_ie) != (en | ie)) || (n_ps != ps);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en <= 1'b0; ie <= 1'b0; ce <= 1'b0; rf <= 1'b0;
      ps <= '0;   cec <= '0;  irq <= 1'b0; sys_rst_req <= 1'b0;
    end else begin
      en <= n_en; ie <= n_ie; ce <= n_ce; rf <= n_rf;
      ps <= n_ps; cec <= n_cec; irq <= n_irq; sys_rst_req <= fire;
    end
  end

  // R4: a set reset flag keeps the enable bit on
  a_r4_flag_holds_en: assert property (@(posedge clk) disable iff (!por_n)
    rf |-> en);
  // R3: without the window, enable cannot be cleared
  a_r3_en_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (en && !ce) |=> en);
  // R5: reset request is a single-cycle pulse
  a_r5_rst_pulse: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_req |=> !sys_rst_req);
  // R8: post-reset defaults accompany the reset request
  a_r8_defaults: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_req |-> (en && rf && !ie && !ce && ps == '0));
  // R6: interrupt stays pending until acknowledged
  a_r6_irq_hold: assert property (@(posedge clk) disable iff (!por_n)
    (irq && !irq_ack) |=> irq);
  // R7: acknowledge clears interrupt enable
  a_r7_ack_clears_ie: assert property (@(posedge clk) disable iff (!por_n)
    irq_ack |=> !ie);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int CE_HOLD   = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       osc_tick,
  input  logic       restart,
  input  logic       irq_ack,
  output logic       irq,
  output logic       sys_rst_req
);
  logic en, ie, ce, rf, cfg_chg, expire, active, clr;
  ps_t  ps;

  assign active    = en | ie;
  assign clr       = cfg_chg | expire | (restart & active);
  assign reg_rdata = {ps, rf, ce, ie, en};

  wdt_regs #(.CE_HOLD(CE_HOLD)) u_regs (
    .clk(clk), .por_n(por_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .irq_ack(irq_ack), .expire(expire), .en(en), .ie(ie), .ce(ce),
    .rf(rf), .ps(ps), .irq(irq), .sys_rst_req(sys_rst_req),
    .cfg_chg(cfg_chg)
  );

  wdt_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
    .clk(clk), .por_n(por_n), .active(active), .ps(ps),
    .tick(osc_tick), .clr(clr), .expire(expire)
  );
endmodule

// File: tb/wdt_timer_test.sv
module wdt_timer_test;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic reg_we = 1'b0, osc_tick = 1'b0, restart = 1'b0, irq_ack = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq, sys_rst_req;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  wdt_timer #(.BASE_LOG2(3), .CE_HOLD(4)) uut (
    .clk(clk), .por_n(por_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .osc_tick(osc_tick), .restart(restart),
    .irq_ack(irq_ack), .irq(irq), .sys_rst_req(sys_rst_req)
  );

  // reference model state
  bit m_en, m_ie, m_ce, m_rf, m_irq, m_rst;
  int m_cec, m_ps, m_cnt;

  function automatic logic [7:0] m_rd();
    return {4'(m_ps), m_rf, m_ce, m_ie, m_en};
  endfunction

  task automatic m_reset();
    m_en = 0; m_ie = 0; m_ce = 0; m_rf = 0; m_irq = 0; m_rst = 0;
    m_cec = 0; m_ps = 0; m_cnt = 0;
  endtask

  task automatic m_step(bit we, logic [7:0] wd, bit tk, bit kk, bit ak);
    int lim, n_cec, n_ps;
    bit act, ex, fire, n_en, n_ie, n_ce, n_rf, chg;
    lim = 1 << (3 + m_ps);
    act = m_en | m_ie;
    ex = act && tk && (m_cnt == lim - 1);
    fire = ex && !m_ie && m_en;
    n_en = m_en; n_ie = m_ie; n_ce = m_ce; n_rf = m_rf; n_cec = m_cec; n_ps = m_ps;
    if (fire) begin
      n_en = 1; n_ie = 0; n_ce = 0; n_rf = 1; n_ps = 0; n_cec = 0;
    end else begin
      if (we) begin
        if (m_ce) begin
          n_en = wd[0] | m_rf; n_ie = wd[1]; n_ps = int'(wd[7:4]);
          n_rf = m_rf & wd[3]; n_ce = 0;
        end else if (wd[2] && wd[0]) begin
          n_ce = 1; n_cec = 3;
        end else begin
          n_en = m_en | wd[0]; n_ie = wd[1]; n_rf = m_rf & wd[3];
        end
      end else if (m_ce) begin
        if (m_cec == 0) n_ce = 0; else n_cec = m_cec - 1;
      end
      if (ak) n_ie = 0;
    end
    m_irq = (ex && m_ie) ? 1'b1 : (ak ? 1'b0 : m_irq);
    chg = ((n_en | n_ie) != act) || (n_ps != m_ps);
    if (chg || ex || (kk && act) || !act) m_cnt = 0;
    else if (tk) m_cnt = m_cnt + 1;
    m_rst = fire;
    m_en = n_en; m_ie = n_ie; m_ce = n_ce; m_rf = n_rf; m_cec = n_cec; m_ps = n_ps;
  endtask

  task automatic chk(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(bit we, logic [7:0] wd, bit tk, bit kk, bit ak);
    reg_we = we; reg_wdata = wd; osc_tick = tk; restart = kk; irq_ack = ak;
    @(posedge clk);
    m_step(we, wd, tk, kk, ak);
    @(negedge clk);
    reg_we = 0; restart = 0; irq_ack = 0;
    chk("R12 model register", int'(reg_rdata), int'(m_rd()));
    chk("R6 model irq", int'(irq), int'(m_irq));
    chk("R5 model reset", int'(sys_rst_req), int'(m_rst));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int n, evts;
    void'($urandom(32'd20251));
    m_reset();
    repeat (3) @(negedge clk);
    por_n = 1;
    // R11 power-on state
    chk("R11 reg", int'(reg_rdata), 'h00);
    chk("R11 irq", int'(irq), 0);
    chk("R11 rst", int'(sys_rst_req), 0);

    // R3 closed-window writes
    cyc(1, 8'h01, 0, 0, 0); chk("R3 set en", int'(reg_rdata), 'h01);
    cyc(1, 8'h00, 0, 0, 0); chk("R3 en sticky", int'(reg_rdata), 'h01);
    cyc(1, 8'h51, 0, 0, 0); chk("R3 ps locked", int'(reg_rdata), 'h01);

    // R1/R5 reset period at ps=0
    cyc(0, 8'h00, 1, 1, 0);
    n = 0;
    while (!sys_rst_req && n < 100) begin cyc(0, 8'h00, 1, 0, 0); n++; end
    chk("R1 R5 period ps0", n, 8);
    chk("R8 defaults", int'(reg_rdata), 'h09);
    cyc(0, 8'h00, 0, 0, 0); chk("R5 one cycle", int'(sys_rst_req), 0);

    // R2 unlock window length
    cyc(1, 8'h05, 0, 0, 0); chk("R2 open", int'(reg_rdata), 'h0D);
    repeat (3) cyc(0, 8'h00, 0, 0, 0);
    chk("R2 still open", int'(reg_rdata), 'h0D);
    cyc(0, 8'h00, 0, 0, 0); chk("R2 closed", int'(reg_rdata), 'h09);

    // R4 window write with reset flag set
    cyc(1, 8'h05, 0, 0, 0);
    cyc(1, 8'h28, 0, 0, 0); chk("R4 en forced", int'(reg_rdata), 'h29);
    cyc(1, 8'h01, 0, 0, 0); chk("R3 flag clear", int'(reg_rdata), 'h21);
    cyc(1, 8'h05, 0, 0, 0); chk("R2 reopen", int'(reg_rdata), 'h25);
    cyc(1, 8'h20, 0, 0, 0); chk("R4 disable", int'(reg_rdata), 'h20);

    // R10 disabled watchdog never fires
    evts = 0;
    repeat (300) begin cyc(0, 8'h00, 1, 0, 0); evts += int'(irq) + int'(sys_rst_req); end
    chk("R10 no timeout", evts, 0);

    // R6 interrupt mode, ps=2
    cyc(1, 8'h02, 1, 0, 0); chk("R3 ie write", int'(reg_rdata), 'h22);
    n = 0;
    while (!irq && n < 200) begin cyc(0, 8'h00, 1, 0, 0); n++; end
    chk("R6 R1 period ps2", n, 32);
    repeat (5) cyc(0, 8'h00, 1, 0, 0);
    chk("R6 irq held", int'(irq), 1);
    cyc(0, 8'h00, 1, 0, 1);
    chk("R7 ack irq", int'(irq), 0);
    chk("R7 ack ie", int'(reg_rdata), 'h20);
    evts = 0;
    repeat (50) begin cyc(0, 8'h00, 1, 0, 0); evts += int'(irq) + int'(sys_rst_req); end
    chk("R10 stopped after ack", evts, 0);

    // R7 interrupt then reset
    cyc(1, 8'h03, 1, 0, 0); chk("R7 mode", int'(reg_rdata), 'h23);
    n = 0;
    while (!irq && n < 200) begin cyc(0, 8'h00, 1, 0, 0); n++; end
    chk("R6 first irq", n, 32);
    cyc(0, 8'h00, 1, 0, 1); n = 1;
    chk("R7 ie cleared", int'(reg_rdata), 'h21);
    while (!sys_rst_req && n < 200) begin cyc(0, 8'h00, 1, 0, 0); n++; end
    chk("R7 reset after ack", n, 32);
    chk("R8 defaults again", int'(reg_rdata), 'h09);

    // R9 restart strobe
    repeat (5) cyc(0, 8'h00, 1, 0, 0);
    cyc(0, 8'h00, 1, 1, 0);
    n = 0;
    while (!sys_rst_req && n < 100) begin cyc(0, 8'h00, 1, 0, 0); n++; end
    chk("R9 restart reload", n, 8);
    evts = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(0, 8'h00, 1, (i % 6) == 5, 0);
      evts += int'(sys_rst_req);
    end
    chk("R9 kept alive", evts, 0);

    // R10 prescaler change restarts, ps=1
    cyc(1, 8'h05, 0, 0, 0);
    cyc(1, 8'h19, 1, 0, 0); chk("R4 ps write", int'(reg_rdata), 'h19);
    n = 0;
    while (!sys_rst_req && n < 100) begin cyc(0, 8'h00, 1, 0, 0); n++; end
    chk("R10 R1 period ps1", n, 16);

    // random phase against the model
    for (int i = 0; i < 20000; i++) begin
      bit we, tk, kk, ak;
      logic [7:0] wd;
      we = ($urandom % 6) == 0;
      wd = 8'($urandom) & 8'h3F;
      tk = ($urandom % 2) == 0;
      kk = ($urandom % 20) == 0;
      ak = ($urandom % 16) == 0;
      cyc(we, wd, tk, kk, ak);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule